// File: doc/BRIEF.md
# Two-Channel Gated Event Counter

This unit measures how a program behaves while it runs. It has two counting channels that work independently. Each channel picks one event source: a bus-clock cycle tick, a data-cache miss strobe that covers reads and writes, or an operand-access strobe for reads and writes to cacheable memory. A channel counts either for the whole time the run signal is high, or only inside a program-counter window. The window opens after the retired PC matches a start address and closes after it matches an end address. One start/end address pair serves both channels.

The unit is set up through a plain register write port. Writes take effect only while the unit is stopped. Each count is 48 bits wide and is read back as two 32-bit words through a read port with a fixed latency of one cycle. Reading the lower word also captures the upper word, so the two halves come from the same instant. If a counter wraps, the channel raises a sticky invalid flag that stays set until that channel is cleared. Writing either window address takes over comparator resources that a break unit may also use, so such a write sets a sticky status output. The cycle event is a tick strobe taken from the bus clock, so the count stays correct when the core-to-bus clock ratio changes during a run. Host software works out ratios, such as hit rate or time spent in a region, from the two counts.

Top module: `dual_perf_monitor`

## Requirements
- R1: After reset, both counts read zero, both invalid flags are low, the window is closed and `cmp_overwritten` is low.
- R2: Bits [1:0] of a channel config word select its event: 0 is the `ev_cycle` tick, 1 is `ev_dmiss`, 2 is `ev_opacc`, and 3 selects no event, so the channel never counts.
- R3: In whole-run mode (config bit 2 = 0), a channel adds one for each clock edge at which `run` is high and its selected strobe is high.
- R4: While `run` is low, no channel count changes, except through a clear.
- R5: In window mode (config bit 2 = 1), a retired PC (`pc_valid` high) equal to the start address opens the window. Counting begins on the next cycle, not on the matching cycle. A start match while the window is already open has no effect.
- R6: When the retired PC equals the end address, the events of that cycle are still counted and the window closes from the next cycle. The end match wins if both addresses match in the same cycle. The window is closed while `run` is low.
- R7: The start address (config address 2) and the end address (config address 3) are each a single register shared by both channels. The most recent accepted write is the one in effect.
- R8: When a counter at its maximum value takes another event, it wraps to zero and sets that channel's invalid flag. The flag stays set until the channel is cleared.
- R9: A config write with bit 3 set resets that channel's count to zero and clears its invalid flag. The channel's event and mode fields are loaded in the same write. Config address 0 selects channel 0 and address 1 selects channel 1.
- R10: Every config write made while `run` is high is ignored, including clears and address writes.
- R11: An accepted write to config address 2 or 3 sets `cmp_overwritten`, which then stays high until reset.
- R12: A read with `rd_en` high returns its word on `rd_data` one clock later. `rd_addr` bit 1 selects the channel and bit 0 selects the upper half. Reading the lower half latches that channel's upper 16 bits, zero-extended to 32, for a later upper-half read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | High while the measured program runs |
| ev_cycle | input | 1 | Bus-clock cycle tick strobe |
| ev_dmiss | input | 1 | Data-cache miss strobe (read or write) |
| ev_opacc | input | 1 | Cacheable operand access strobe (read or write) |
| pc_valid | input | 1 | A retired PC is present on `pc` |
| pc | input | PC_W | Retired program counter |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 3 | Config address: 0/1 channel config, 2 start address, 3 end address |
| cfg_wdata | input | 32 | Config write data |
| rd_en | input | 1 | Count read request |
| rd_addr | input | 2 | Read address: {channel, upper half} |
| rd_data | output | 32 | Read data, valid one cycle after the request |
| invalid | output | 2 | Per-channel sticky overflow flags |
| cmp_overwritten | output | 1 | Sticky flag: window addresses have taken over the comparators |

## Verification
A strobe or PC that is present at a clock edge changes a count at that same edge. The window flag follows one edge after a start or end match, so a start-address cycle adds nothing and the first counted event comes one cycle later. A read request produces data one edge later. The bench drives every input on the falling edge and samples outputs on the falling edge that follows the edge concerned. It reads counts only after `run` has been low for a full cycle, so it always compares settled values with totals its own functions build cycle by cycle.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  typedef enum logic [1:0] {
    EV_CYCLE = 2'd0,
    EV_DMISS = 2'd1,
    EV_OPACC = 2'd2,
    EV_NONE  = 2'd3
  } ev_sel_e;

  typedef struct packed {
    logic    win_mode;
    ev_sel_e sel;
  } ch_cfg_t;

  localparam logic [2:0] ADDR_CH0   = 3'd0;
  localparam logic [2:0] ADDR_CH1   = 3'd1;
  localparam logic [2:0] ADDR_START = 3'd2;
  localparam logic [2:0] ADDR_END   = 3'd3;
  localparam int         CLR_BIT    = 3;
endpackage

// File: rtl/pmu_window.sv
module pmu_window #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            pc_valid,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] start_pc,
  input  logic [PC_W-1:0] end_pc,
  output logic            win_open
);
  logic hit_start, hit_end;

  assign hit_start = pc_valid && (pc == start_pc);
  assign hit_end   = pc_valid && (pc == end_pc);

  // end match has priority; an extra start match while open keeps it open
  always_ff @(posedge clk) begin
    if (!rst_n)         win_open <= 1'b0;
    else if (!run)      win_open <= 1'b0;
    else if (hit_end)   win_open <= 1'b0;
    else if (hit_start) win_open <= 1'b1;
  end
endmodule

// File: rtl/pmu_channel.sv
module pmu_channel
  import pmu_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ch_cfg_t          cfg,
  input  logic             clr,
  input  logic             run,
  input  logic             win_open,
  input  logic             ev_cycle,
  input  logic             ev_dmiss,
  input  logic             ev_opacc,
  output logic [CNT_W-1:0] cnt,
  output logic             invalid
);
  logic ev_sel, gate, hit;

  always_comb begin
    unique case (cfg.sel)
      EV_CYCLE: ev_sel = ev_cycle;
      EV_DMISS: ev_sel = ev_dmiss;
      EV_OPACC: ev_sel = ev_opacc;
      default:  ev_sel = 1'b0;
    endcase
  end

  assign gate = cfg.win_mode ? win_open : 1'b1;
  assign hit  = run && gate && ev_sel;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt     <= '0;
      invalid <= 1'b0;
    end else if (hit) begin
      cnt <= cnt + CNT_W'(1);
      if (&cnt) invalid <= 1'b1;
    end
  end
endmodule

// File: rtl/pmu_readout.sv
module pmu_readout #(
  parameter int CNT_W = 48,
  parameter int NCH   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH-1:0][CNT_W-1:0] cnt,
  input  logic                      rd_en,
  input  logic [1:0]                rd_addr,
  output logic [31:0]               rd_data
);
  localparam int PAD = 64 - CNT_W;
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0][63:0] ext;
  logic [NCH-1:0][31:0] hi_q;
  logic [CH_W-1:0]      ch;

  for (genvar g = 0; g < NCH; g++) begin : g_ext
    assign ext[g] = {{PAD{1'b0}}, cnt[g]};
  end

  assign ch = CH_W'(rd_addr[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      hi_q    <= '0;
    end else if (rd_en) begin
      if (rd_addr[0]) begin
        rd_data <= hi_q[ch];
      end else begin
        rd_data  <= ext[ch][31:0];
        hi_q[ch] <= ext[ch][63:32];
      end
    end
  end
endmodule

// File: rtl/dual_perf_monitor.sv
module dual_perf_monitor
  import pmu_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int CNT_W = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            ev_cycle,
  input  logic            ev_dmiss,
  input  logic            ev_opacc,
  input  logic            pc_valid,
  input  logic [PC_W-1:0] pc,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_addr,
  input  logic [31:0]     cfg_wdata,
  input  logic            rd_en,
  input  logic [1:0]      rd_addr,
  output logic [31:0]     rd_data,
  output logic [1:0]      invalid,
  output logic            cmp_overwritten
);
  localparam int NCH = 2;

  logic                      wr_ok;
  logic [PC_W-1:0]           start_pc_q, end_pc_q;
  logic                      win_open;
  ch_cfg_t [NCH-1:0]         cfg_q;
  logic [NCH-1:0]            clr_ch;
  logic [NCH-1:0][CNT_W-1:0] cnt_q;

  assign wr_ok = cfg_we && !run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_pc_q      <= '0;
      end_pc_q        <= '0;
      cmp_overwritten <= 1'b0;
    end else if (wr_ok) begin
      if (cfg_addr == ADDR_START) begin
        start_pc_q      <= cfg_wdata[PC_W-1:0];
        cmp_overwritten <= 1'b1;
      end
      if (cfg_addr == ADDR_END) begin
        end_pc_q        <= cfg_wdata[PC_W-1:0];
        cmp_overwritten <= 1'b1;
      end
    end
  end

  pmu_window #(.PC_W(PC_W)) u_win (
    .clk(clk), .rst_n(rst_n), .run(run), .pc_valid(pc_valid), .pc(pc),
    .start_pc(start_pc_q), .end_pc(end_pc_q), .win_open(win_open)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel_me;
    assign sel_me    = wr_ok && (cfg_addr == 3'(g));
    assign clr_ch[g] = sel_me && cfg_wdata[CLR_BIT];

    always_ff @(posedge clk) begin
      if (!rst_n)      cfg_q[g] <= '0;
      else if (sel_me) cfg_q[g] <= ch_cfg_t'(cfg_wdata[2:0]);
    end

    pmu_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .cfg(cfg_q[g]), .clr(clr_ch[g]), .run(run),
      .win_open(win_open), .ev_cycle(ev_cycle), .ev_dmiss(ev_dmiss),
      .ev_opacc(ev_opacc), .cnt(cnt_q[g]), .invalid(invalid[g])
    );
  end

  pmu_readout #(.CNT_W(CNT_W), .NCH(NCH)) u_rd (
    .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker
  import pmu_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int CNT_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             pc_valid,
  input logic [PC_W-1:0]  pc,
  input logic [PC_W-1:0]  start_pc,
  input logic [PC_W-1:0]  end_pc,
  input logic             win_open,
  input logic [CNT_W-1:0] cnt0,
  input logic             clr0,
  input logic             inv0,
  input ch_cfg_t          cfg0,
  input logic             cmp_ow
);
  // R4
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr0) |=> $stable(cnt0));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr0 |=> (cnt0 == $past(cnt0)) || (cnt0 == CNT_W'($past(cnt0) + CNT_W'(1))));

  // R8
  sticky_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv0 && !clr0) |=> inv0);

  // R5
  window_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pc_valid && pc == start_pc && pc != end_pc) |=> win_open);

  // R6
  window_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pc_valid && pc == end_pc) |=> !win_open);

  // R10
  frozen_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> ($stable(cfg0) && $stable(start_pc) && $stable(end_pc)));

  // R11
  sticky_ow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_ow |=> cmp_ow);
endmodule

bind dual_perf_monitor pmu_checker #(.PC_W(PC_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .pc_valid(pc_valid), .pc(pc),
  .start_pc(start_pc_q), .end_pc(end_pc_q), .win_open(win_open),
  .cnt0(cnt_q[0]), .clr0(clr_ch[0]), .inv0(invalid[0]), .cfg0(cfg_q[0]),
  .cmp_ow(cmp_overwritten)
);

// File: tb/dual_perf_monitor_test.sv
`timescale 1ns/1ps
module dual_perf_monitor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, ev_cycle = 1'b0, ev_dmiss = 1'b0, ev_opacc = 1'b0;
  logic pc_valid = 1'b0;
  logic [31:0] pc = '0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic rd_en = 1'b0;
  logic [1:0] rd_addr = '0;
  logic [31:0] rd_data, rd_data_s;
  logic [1:0] invalid, invalid_s;
  logic cmp_ow, cmp_ow_s;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  logic [31:0] rv, rvs;

  always #2.5 clk = ~clk;

  dual_perf_monitor uut (
    .clk(clk), .rst_n(rst_n), .run(run), .ev_cycle(ev_cycle), .ev_dmiss(ev_dmiss),
    .ev_opacc(ev_opacc), .pc_valid(pc_valid), .pc(pc), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .invalid(invalid), .cmp_overwritten(cmp_ow)
  );

  // narrow instance so counter wrap is reachable
  dual_perf_monitor #(.CNT_W(10)) uut_small (
    .clk(clk), .rst_n(rst_n), .run(run), .ev_cycle(ev_cycle), .ev_dmiss(ev_dmiss),
    .ev_opacc(ev_opacc), .pc_valid(pc_valid), .pc(pc), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data_s), .invalid(invalid_s), .cmp_overwritten(cmp_ow_s)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    rv = rd_data; rvs = rd_data_s;
  endtask

  task automatic rd_cnt(input int ch, output logic [63:0] v);
    logic [31:0] lo;
    rd(2'(ch * 2));
    lo = rv;
    rd(2'(ch * 2 + 1));
    v = {rv, lo};
  endtask

  function automatic bit ev_of(input logic [1:0] sel, input bit c, input bit m, input bit o);
    case (sel)
      2'd0: return c;
      2'd1: return m;
      2'd2: return o;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] cfgw(input bit clr, input bit win, input logic [1:0] sel);
    return {28'd0, clr, win, sel};
  endfunction

  task automatic stop_idle();
    @(negedge clk);
    run = 1'b0; ev_cycle = 1'b0; ev_dmiss = 1'b0; ev_opacc = 1'b0; pc_valid = 1'b0;
  endtask

  initial begin
    logic [63:0] v, e0, e1;
    bit open;
    void'($urandom(32'h5eed_1234));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_cnt(0, v); chk(v == 0, "R1 ch0 count", v, 0);
    rd_cnt(1, v); chk(v == 0, "R1 ch1 count", v, 0);
    chk(invalid == 2'b00, "R1 invalid", invalid, 0);
    chk(cmp_ow == 1'b0, "R1 cmp_overwritten", cmp_ow, 0);

    // R2/R3 random whole-run counting, several select pairs
    for (int ph = 0; ph < 4; ph++) begin
      logic [1:0] s0, s1;
      s0 = 2'(ph); s1 = 2'((ph + 1) % 4);
      wr(3'd0, cfgw(1, 0, s0));
      wr(3'd1, cfgw(1, 0, s1));
      e0 = 0; e1 = 0;
      for (int i = 0; i < 600; i++) begin
        bit c, m, o, r;
        c = 1'($urandom_range(0, 1)); m = 1'($urandom_range(0, 1));
        o = 1'($urandom_range(0, 1)); r = ($urandom_range(0, 7) != 0);
        @(negedge clk);
        run = r; ev_cycle = c; ev_dmiss = m; ev_opacc = o;
        if (r) begin
          e0 += 64'(ev_of(s0, c, m, o));
          e1 += 64'(ev_of(s1, c, m, o));
        end
      end
      stop_idle();
      rd_cnt(0, v); chk(v == e0, $sformatf("R2 R3 ch0 sel%0d", s0), v, e0);
      rd_cnt(1, v); chk(v == e1, $sformatf("R2 R3 ch1 sel%0d", s1), v, e1);
    end

    // R4 stopped: strobes without run change nothing
    @(negedge clk);
    ev_cycle = 1'b1; ev_dmiss = 1'b1; ev_opacc = 1'b1;
    repeat (20) @(negedge clk);
    stop_idle();
    rd_cnt(0, v); chk(v == e0, "R4 ch0 held while stopped", v, e0);

    // R10 writes during run ignored (clear and start address)
    wr(3'd0, cfgw(1, 0, 2'd0));
    @(negedge clk); run = 1'b1; ev_cycle = 1'b0;
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = cfgw(1, 0, 2'd3);
    ev_cycle = 1'b1;
    @(negedge clk); cfg_we = 1'b0; ev_cycle = 1'b1;
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 3'd2; cfg_wdata = 32'h777;
    @(negedge clk); cfg_we = 1'b0;
    stop_idle();
    rd_cnt(0, v); chk(v == 4, "R10 clear/config ignored while running", v, 4);
    chk(cmp_ow == 1'b0, "R10 address write ignored while running", cmp_ow, 0);

    // R7 R11 shared window, last write wins
    wr(3'd2, 32'h300);
    chk(cmp_ow == 1'b1, "R11 cmp_overwritten after address write", cmp_ow, 1);
    wr(3'd2, 32'h100);
    wr(3'd3, 32'h200);
    wr(3'd0, cfgw(1, 1, 2'd0));
    wr(3'd1, cfgw(1, 0, 2'd0));

    // R5 R6 directed window sequence, ev_cycle high every cycle
    begin
      logic [31:0] seq [10];
      seq = '{32'h300, 32'h050, 32'h100, 32'h104, 32'h100, 32'h108,
              32'h10c, 32'h200, 32'h204, 32'h208};
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        run = 1'b1; ev_cycle = 1'b1; pc_valid = 1'b1; pc = seq[i];
      end
    end
    stop_idle();
    // counted cycles: after 0x100 at index 2 -> indices 3..7 (end included)
    rd_cnt(0, v); chk(v == 5, "R5 R6 R7 window count", v, 5);
    rd_cnt(1, v); chk(v == 10, "R7 whole-run channel alongside window", v, 10);

    // R5 R6 random window traffic, ch0 cycles, ch1 data misses
    wr(3'd0, cfgw(1, 1, 2'd0));
    wr(3'd1, cfgw(1, 1, 2'd1));
    e0 = 0; e1 = 0; open = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      bit c, m, vld;
      logic [31:0] p;
      int k;
      c = 1'($urandom_range(0, 1)); m = 1'($urandom_range(0, 1));
      vld = ($urandom_range(0, 3) != 0);
      k = $urandom_range(0, 9);
      p = (k == 0) ? 32'h100 : (k == 1) ? 32'h200 : 32'h400 + 32'(k);
      @(negedge clk);
      run = 1'b1; ev_cycle = c; ev_dmiss = m; pc_valid = vld; pc = p;
      if (open) begin e0 += 64'(c); e1 += 64'(m); end
      if (vld && p == 32'h200) open = 1'b0;
      else if (vld && p == 32'h100) open = 1'b1;
    end
    stop_idle();
    rd_cnt(0, v); chk(v == e0, "R5 R6 random window ch0", v, e0);
    rd_cnt(1, v); chk(v == e1, "R5 R6 random window ch1", v, e1);

    // R8 R9 wrap on the narrow instance
    wr(3'd0, cfgw(1, 0, 2'd0));
    @(negedge clk); run = 1'b1; ev_cycle = 1'b1;
    repeat (1022) @(negedge clk);
    stop_idle();
    rd(2'd0);
    chk(rvs == 1023, "R8 narrow count at max", rvs, 1023);
    chk(invalid_s[0] == 1'b0, "R8 no invalid before wrap", invalid_s[0], 0);
    @(negedge clk); run = 1'b1; ev_cycle = 1'b1;
    stop_idle();
    rd(2'd0);
    chk(rvs == 0, "R8 narrow count wraps to zero", rvs, 0);
    chk(invalid_s[0] == 1'b1, "R8 invalid set on wrap", invalid_s[0], 1);
    chk(invalid[0] == 1'b0, "R8 wide channel still valid", invalid[0], 0);
    rd_cnt(0, v); chk(v == 1024, "R12 wide count read as two words", v, 1024);
    @(negedge clk); run = 1'b1; ev_cycle = 1'b1;
    repeat (4) @(negedge clk);
    stop_idle();
    chk(invalid_s[0] == 1'b1, "R8 invalid stays set", invalid_s[0], 1);
    wr(3'd0, cfgw(1, 0, 2'd0));
    chk(invalid_s[0] == 1'b0, "R9 clear drops invalid", invalid_s[0], 0);
    rd(2'd0);
    chk(rvs == 0, "R9 clear zeroes narrow count", rvs, 0);
    chk(rv == 0, "R9 clear zeroes wide count", rv, 0);

    // R12 read latency: data present one edge after request
    @(negedge clk); run = 1'b1; ev_cycle = 1'b1;
    repeat (6) @(negedge clk);
    stop_idle();
    @(negedge clk); rd_en = 1'b1; rd_addr = 2'd0;
    @(negedge clk); rd_en = 1'b0;
    chk(rd_data == 7, "R12 data one cycle after request", rd_data, 7);
    @(negedge clk);
    chk(rd_data == 7, "R12 data held without request", rd_data, 7);
    rd(2'd1);
    chk(rv == 0, "R12 upper half of small count", rv, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule